// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block keeps track of which power mode the system is in and moves it between four modes: normal run, a reduced-power run mode, a low-leakage stop, and a very-low-leakage stop that has several sub-levels. A deep stop is entered only when three things hold at once. The processor signals a sleep with its deep-sleep flag set, the stop-select field names that mode, and the matching allow bit has been set. Leaving a deep stop always returns the system to normal run. The exit is caused either by a wakeup source that is enabled or by the external reset pin.

The allow bits can be written only once after each system reset. A sleep request that names a deep mode whose allow bit is clear does not change the mode. Instead it raises a sticky abort flag. The core clock enable goes low in the deep stops, unless debug is enabled. All control and status pins are plain levels or single-cycle pulses, so no stream handshake is used.

Top module: `pwr_mode_seq`

## Requirements
- R1: After `rst_n` is released, the outputs are: `mode` = run (3'b000), `vll_level` = 0, `abort_flag` = 0, `allow_q` = 0, and `core_clk_en` = 1.
- R2: A sleep request moves `mode` to very-low-leakage stop (3'b100) on the next clock. This happens only when `allow_q[1]` = 1 and `stop_sel` = 3'b100.
- R3: A sleep request moves `mode` to low-leakage stop (3'b011) on the next clock. This happens only when `allow_q[0]` = 1 and `stop_sel` = 3'b011.
- R4: Both deep stops can be entered from run (3'b000) and from reduced-power run (3'b001).
- R5: A sleep request is `deep_flag` = 1 together with either `sleep_now` or `sleep_on_exit`. When `deep_flag` = 0, a sleep pulse is ignored.
- R6: On entry to very-low-leakage stop, `level_in` is latched into `vll_level`. Later changes of `level_in` do not alter it.
- R7: In a deep stop, a `wake_strobe` bit whose `wake_en` bit is 1 returns `mode` to run on the next clock. A strobe whose enable bit is 0 is ignored.
- R8: A deep stop never exits directly to reduced-power run, even while `lp_run_req` = 1.
- R9: `rst_pin` = 1 forces `mode` to run and `vll_level` to 0 on the next clock, from any mode.
- R10: A sleep request whose `stop_sel` names a deep mode with a clear allow bit leaves `mode` unchanged. It sets `abort_flag`, which stays set until `rst_n`.
- R11: The first `allow_wr` pulse after `rst_n` loads `allow_wdata` into `allow_q` (bit 0 permits low-leakage stop, bit 1 permits very-low-leakage stop). Later writes have no effect.
- R12: `core_clk_en` is 0 in either deep stop when `dbg_en` = 0, and is 1 whenever `dbg_en` = 1.
- R13: With no sleep request, `lp_run_req` = 1 moves run to reduced-power run, and `lp_run_req` = 0 moves reduced-power run back to run, each on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| rst_pin | input | 1 | External reset pin, active high, sampled on the clock |
| allow_wr | input | 1 | Write strobe for the allow bits |
| allow_wdata | input | 2 | Allow bits to write (bit 0 low-leakage, bit 1 very-low-leakage) |
| stop_sel | input | 3 | Stop-mode select (3'b011 low-leakage, 3'b100 very-low-leakage) |
| level_in | input | LVL_W | Sub-level for very-low-leakage stop |
| lp_run_req | input | 1 | Request for reduced-power run |
| sleep_now | input | 1 | Processor sleep-now pulse |
| sleep_on_exit | input | 1 | Processor sleep-on-exit pulse |
| deep_flag | input | 1 | Processor deep-sleep flag |
| wake_strobe | input | N_WAKE | Wakeup source pulses |
| wake_en | input | N_WAKE | Per-source wakeup enables |
| dbg_en | input | 1 | Debug enable |
| mode | output | 3 | Current mode code |
| core_clk_en | output | 1 | Core clock gate enable |
| vll_level | output | LVL_W | Latched very-low-leakage sub-level |
| abort_flag | output | 1 | Sticky flag for a refused deep-stop request |
| allow_q | output | 2 | Current allow bits |

## Verification
The assertions assume the following about the inputs:
- Wakeup strobes and sleep pulses are already synchronized to `clk` and each lasts a single cycle.
- `rst_pin` is a clean synchronous level.

The stimulus changes every input only on the falling edge. It raises each sleep or wake pulse for exactly one cycle. It asserts `rst_pin` only as a one-cycle pulse, so every transition the assertions reason about is driven by a single, well-defined input cycle.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [2:0] {
    M_RUN  = 3'b000,
    M_VLPR = 3'b001,
    M_LLS  = 3'b011,
    M_VLLS = 3'b100
  } mode_e;

  localparam logic [2:0] SEL_LLS  = 3'b011;
  localparam logic [2:0] SEL_VLLS = 3'b100;
endpackage

// File: rtl/pms_protect.sv
module pms_protect #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] allow_q
);
  logic locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow_q  <= '0;
      locked_q <= 1'b0;
    end else if (wr && !locked_q) begin
      allow_q  <= wdata;
      locked_q <= 1'b1;
    end
  end

  // R11: once written, the allow bits hold until system reset
  p_allow_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(allow_q));
endmodule

// File: rtl/pms_wake.sv
module pms_wake #(
  parameter int N = 8
) (
  input  logic [N-1:0] strobe,
  input  logic [N-1:0] en,
  output logic         hit
);
  logic [N-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign gated[i] = strobe[i] & en[i];
  end

  assign hit = |gated;
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_pin,
  input  logic             sleep_now,
  input  logic             sleep_on_exit,
  input  logic             deep_flag,
  input  logic [2:0]       stop_sel,
  input  logic [LVL_W-1:0] level_in,
  input  logic             lp_run_req,
  input  logic [1:0]       allow,
  input  logic             wake_hit,
  output mode_e            mode_q,
  output logic [LVL_W-1:0] level_q,
  output logic             abort_q
);
  mode_e            mode_d;
  logic [LVL_W-1:0] level_d;
  logic             abort_d;
  logic             sleep_req, in_active, in_deep;
  logic             vlls_ok, lls_ok, denied;

  assign sleep_req = (sleep_now | sleep_on_exit) & deep_flag;
  assign in_active = (mode_q == M_RUN) || (mode_q == M_VLPR);
  assign in_deep   = (mode_q == M_LLS) || (mode_q == M_VLLS);
  assign vlls_ok   = sleep_req && (stop_sel == SEL_VLLS) && allow[1];
  assign lls_ok    = sleep_req && (stop_sel == SEL_LLS) && allow[0];
  assign denied    = sleep_req && (((stop_sel == SEL_VLLS) && !allow[1]) ||
                                   ((stop_sel == SEL_LLS) && !allow[0]));

  always_comb begin
    mode_d  = mode_q;
    level_d = level_q;
    abort_d = abort_q;
    if (rst_pin) begin
      mode_d  = M_RUN;
      level_d = '0;
    end else if (in_active) begin
      if (vlls_ok) begin
        mode_d  = M_VLLS;
        level_d = level_in;
      end else if (lls_ok) begin
        mode_d = M_LLS;
      end else if (denied) begin
        abort_d = 1'b1;
      end else if (mode_q == M_RUN && lp_run_req) begin
        mode_d = M_VLPR;
      end else if (mode_q == M_VLPR && !lp_run_req) begin
        mode_d = M_RUN;
      end
    end else if (in_deep && wake_hit) begin
      mode_d = M_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_RUN;
      level_q <= '0;
      abort_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      level_q <= level_d;
      abort_q <= abort_d;
    end
  end

  // R2: very-low-leakage stop is reached only through a permitted request
  p_vlls_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_VLLS && !(sleep_req && stop_sel == SEL_VLLS && allow[1]))
      |=> mode_q != M_VLLS);
  // R8: a deep stop leaves only to run
  p_deep_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_deep |=> (mode_q == M_RUN || mode_q == M_LLS || mode_q == M_VLLS));
  // R7: a deep stop is held without an enabled wake or reset pin
  p_deep_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_deep && !wake_hit && !rst_pin) |=> $stable(mode_q));
  // R9: reset pin forces run and clears the sub-level
  p_rst_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pin |=> (mode_q == M_RUN && level_q == '0));
  // R10: abort flag is sticky
  p_abort_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |=> abort_q);
  // R6: sub-level only changes on entry or reset pin
  p_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_VLLS && !rst_pin) |=> $stable(level_q));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int N_WAKE = 8,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pin,
  input  logic              allow_wr,
  input  logic [1:0]        allow_wdata,
  input  logic [2:0]        stop_sel,
  input  logic [LVL_W-1:0]  level_in,
  input  logic              lp_run_req,
  input  logic              sleep_now,
  input  logic              sleep_on_exit,
  input  logic              deep_flag,
  input  logic [N_WAKE-1:0] wake_strobe,
  input  logic [N_WAKE-1:0] wake_en,
  input  logic              dbg_en,
  output logic [2:0]        mode,
  output logic              core_clk_en,
  output logic [LVL_W-1:0]  vll_level,
  output logic              abort_flag,
  output logic [1:0]        allow_q
);
  mode_e mode_q;
  logic  wake_hit;

  pms_protect #(.W(2)) u_prot (
    .clk(clk), .rst_n(rst_n), .wr(allow_wr), .wdata(allow_wdata),
    .allow_q(allow_q)
  );

  pms_wake #(.N(N_WAKE)) u_wake (
    .strobe(wake_strobe), .en(wake_en), .hit(wake_hit)
  );

  pms_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin),
    .sleep_now(sleep_now), .sleep_on_exit(sleep_on_exit),
    .deep_flag(deep_flag), .stop_sel(stop_sel), .level_in(level_in),
    .lp_run_req(lp_run_req), .allow(allow_q), .wake_hit(wake_hit),
    .mode_q(mode_q), .level_q(vll_level), .abort_q(abort_flag)
  );

  assign mode        = mode_q;
  assign core_clk_en = dbg_en || (mode_q == M_RUN) || (mode_q == M_VLPR);

  // R12: deep stops gate the core clock unless debug is on
  p_clk_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'b011 || mode == 3'b100) && !dbg_en) |-> !core_clk_en);
  p_clk_dbg_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_en |-> core_clk_en);
endmodule

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int LW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_pin = 0, allow_wr = 0, lp_run_req = 0;
  logic sleep_now = 0, sleep_on_exit = 0, deep_flag = 0, dbg_en = 0;
  logic [1:0] allow_wdata = '0;
  logic [2:0] stop_sel = '0;
  logic [LW-1:0] level_in = '0;
  logic [NW-1:0] wake_strobe = '0, wake_en = '0;
  logic [2:0] mode;
  logic core_clk_en, abort_flag;
  logic [LW-1:0] vll_level;
  logic [1:0] allow_q;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_seq #(.N_WAKE(NW), .LVL_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .allow_wr(allow_wr),
    .allow_wdata(allow_wdata), .stop_sel(stop_sel), .level_in(level_in),
    .lp_run_req(lp_run_req), .sleep_now(sleep_now),
    .sleep_on_exit(sleep_on_exit), .deep_flag(deep_flag),
    .wake_strobe(wake_strobe), .wake_en(wake_en), .dbg_en(dbg_en),
    .mode(mode), .core_clk_en(core_clk_en), .vll_level(vll_level),
    .abort_flag(abort_flag), .allow_q(allow_q)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // one-cycle deep sleep pulse; use_exit picks sleep_on_exit
  task automatic sleep_pulse(logic use_exit, logic deep);
    sleep_now = !use_exit; sleep_on_exit = use_exit; deep_flag = deep;
    step();
    sleep_now = 0; sleep_on_exit = 0; deep_flag = 0;
  endtask

  task automatic wake_pulse(logic [NW-1:0] s);
    wake_strobe = s; step(); wake_strobe = '0;
  endtask

  task automatic t_reset();
    check("R1 mode", mode, 3'b000);
    check("R1 level", vll_level, 0);
    check("R1 abort", abort_flag, 0);
    check("R1 allow", allow_q, 0);
    check("R1 clk", core_clk_en, 1);
  endtask

  task automatic t_abort();
    stop_sel = 3'b100; sleep_pulse(0, 1);
    check("R10 mode stays", mode, 3'b000);
    check("R10 abort set", abort_flag, 1);
    stop_sel = 3'b011; sleep_pulse(1, 1);
    check("R10 lls denied", mode, 3'b000);
    step();
    check("R10 sticky", abort_flag, 1);
  endtask

  task automatic t_allow_once();
    allow_wdata = 2'b11; allow_wr = 1; step(); allow_wr = 0;
    check("R11 first write", allow_q, 2'b11);
    allow_wdata = 2'b00; allow_wr = 1; step(); allow_wr = 0;
    check("R11 second ignored", allow_q, 2'b11);
  endtask

  task automatic t_deep_flag();
    stop_sel = 3'b011; sleep_pulse(0, 0);
    check("R5 no deep flag", mode, 3'b000);
  endtask

  task automatic t_lls();
    wake_en = 8'b0000_0100;
    stop_sel = 3'b011; sleep_pulse(0, 1);
    check("R3 enter lls", mode, 3'b011);
    check("R12 clk off", core_clk_en, 0);
    wake_pulse(8'b0001_0000);
    check("R7 masked wake", mode, 3'b011);
    wake_pulse(8'b0000_0100);
    check("R7 enabled wake", mode, 3'b000);
  endtask

  task automatic t_vlpr_vlls();
    lp_run_req = 1; step();
    check("R13 to vlpr", mode, 3'b001);
    level_in = 2'd2; stop_sel = 3'b100; sleep_pulse(1, 1);
    check("R4 vlls from vlpr", mode, 3'b100);
    check("R6 level latched", vll_level, 2);
    level_in = 2'd1; step();
    check("R6 level held", vll_level, 2);
    wake_pulse(8'b0000_0100);
    check("R8 exit to run", mode, 3'b000);
    lp_run_req = 0; step();
    check("R13 stays run", mode, 3'b000);
    lp_run_req = 1; step();
    lp_run_req = 0; step();
    check("R13 back to run", mode, 3'b000);
  endtask

  task automatic t_dbg_rst_pin();
    dbg_en = 1; level_in = 2'd3; stop_sel = 3'b100; sleep_pulse(0, 1);
    check("R2 enter vlls", mode, 3'b100);
    check("R12 dbg clk on", core_clk_en, 1);
    rst_pin = 1; step(); rst_pin = 0;
    check("R9 mode run", mode, 3'b000);
    check("R9 level clear", vll_level, 0);
    dbg_en = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_abort();
    t_allow_once();
    t_deep_flag();
    t_lls();
    t_vlpr_vlls();
    t_dbg_rst_pin();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule